// File: doc/BRIEF.md
# Input Scan Channel Router

This block sits between the tester's compressed-stimulus input channels and the decompressor inputs of a set of embedded cores. Every input channel drives its own one-of-N selector. A per-channel address decides which core the channel feeds for the current group of patterns. An address at or above the core count parks the channel, so it feeds no core at all. The routing path from channel to core input is purely combinational. Only the addresses are stored.

The addresses are written through a serial shift chain into a shadow register. They reach the selectors only when an update strobe is given, so a new configuration can be shifted in while patterns run on the old one. The lowest-numbered inputs of each core are OR gates with several legs, and each leg comes from a different channel. This lets the scheduler feed those heavily used inputs from more than one channel. A configurable number of identical copies of the last core are wired to the same routing result, so they receive the same stimulus in broadcast fashion.

Top module: `scan_chan_router`

## Requirements
- R1: Each channel drives at most one core terminal at a time. Address value c routes the channel only to the terminal that core c has on that channel's selector.
- R2: Shifting the chain without an update strobe leaves the routing unchanged.
- R3: While `cfgShiftEn` is high, each clock shifts `cfgSerIn` into the top bit of the chain, and the other bits move one place toward bit 0. After 8 shifts (with the default widths), the first bit sent sits at bit 0. Selector d takes its 2-bit address from chain bits [2d+1:2d], least significant bit first.
- R4: A high `cfgUpdate` copies the chain into the active addresses on that clock edge. When a shift and an update happen on the same edge, the update copies the chain contents from before the shift.
- R5: After reset, every channel is parked (address 3), so every `coreData` bit is 0.
- R6: A parked channel (address 3 or above with the defaults) contributes 0 to every core input.
- R7: Core c has 4 terminals, numbered t = 0..3, and terminal t is wired to the selector of channel (c + t) mod 4. The two legs of input 0 are terminals 0 and 1. Inputs 1 and 2 are terminals 2 and 3.
- R8: A core input with several legs equals the OR of the channels currently routed to its legs.
- R9: Physical core port p (whose bits are `coreData[3p+2:3p]`) carries the stimulus of logical core min(p, 2). Ports 2 and 3 therefore always receive the same stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the address registers |
| rstN | input | 1 | Active-low synchronous reset |
| chanIn | input | CH_NUM (4) | Compressed stimulus from the tester input channels |
| cfgShiftEn | input | 1 | Shift enable for the address chain |
| cfgSerIn | input | 1 | Serial data into the address chain |
| cfgUpdate | input | 1 | Copies the chain into the active addresses |
| coreData | output | PHYS_NUM*CORE_IN (12) | Decompressor inputs of all physical cores, 3 bits per core |

## Verification
The bench drives the channels with one-hot values, all-ones, and random words. The one-hot values show which single terminal each channel reaches. All-ones shows whether any terminal is missing or driven twice. Hand-picked configurations cover specific behaviours: two legs of the same OR input routed together, all channels aimed at the mirrored core, a mix of parked and live channels, and a distinct address on every selector, which shows whether the chain bit order is right. A shift without an update, and a shift that coincides with an update, tell the shadow register apart from the active addresses. Random address sets combined with random channel words then compare every core input with the OR of the channels routed to it.

// File: rtl/scr_pkg.sv
package scr_pkg;

  // Strobes from the configuration control to the routing datapath
  typedef struct packed {
    logic load;   // copy the shadow chain into the active addresses
  } strobes_t;

  // Number of selector legs that feed core input j
  function automatic int legsOf(int j, int orLow, int fanIn);
    return (j < orLow) ? fanIn : 1;
  endfunction

  // Terminal number of leg f of core input j
  function automatic int termOf(int j, int f, int orLow, int fanIn);
    return (j < orLow) ? (j * fanIn + f) : (orLow * fanIn + (j - orLow));
  endfunction

  // Selector (channel) that serves terminal t of core c
  function automatic int demuxOf(int c, int t, int chNum);
    return (c + t) % chNum;
  endfunction

endpackage

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
#(
  parameter int CH_NUM   = 4,
  parameter int CORE_NUM = 3
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  logic                                        cfgShiftEn,
  input  logic                                        cfgSerIn,
  input  logic                                        cfgUpdate,
  output logic [CH_NUM*$clog2(CORE_NUM+1)-1:0]        shadowBits,
  output strobes_t                                    strobe
);
  localparam int ADDR_W  = $clog2(CORE_NUM + 1);
  localparam int CHAIN_W = CH_NUM * ADDR_W;

  // Shadow chain: new bits enter at the top and move toward bit 0
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowBits <= '0;
    end else if (cfgShiftEn) begin
      shadowBits <= {cfgSerIn, shadowBits[CHAIN_W-1:1]};
    end
  end

  always_comb begin
    strobe      = '0;
    strobe.load = cfgUpdate;
  end

endmodule

// File: rtl/scr_demux.sv
module scr_demux #(
  parameter int DEST_NUM = 3,
  parameter int ADDR_W   = 2
) (
  input  logic                chanBit,
  input  logic [ADDR_W-1:0]   sel,
  output logic [DEST_NUM-1:0] dest
);
  // Unselected outputs and out-of-range selects give 0
  always_comb begin
    for (int c = 0; c < DEST_NUM; c++) begin
      dest[c] = chanBit & (sel == ADDR_W'(c));
    end
  end
endmodule

// File: rtl/scr_route.sv
module scr_route
  import scr_pkg::*;
#(
  parameter int CH_NUM       = 4,
  parameter int CORE_NUM     = 3,
  parameter int CORE_IN      = 3,
  parameter int OR_LOW       = 1,
  parameter int OR_FANIN     = 2,
  parameter int BCAST_COPIES = 2
) (
  input  logic [CH_NUM*CORE_NUM-1:0]                       demuxOut,
  output logic [(CORE_NUM-1+BCAST_COPIES)*CORE_IN-1:0]     coreData
);
  localparam int PHYS_NUM  = CORE_NUM - 1 + BCAST_COPIES;
  localparam int LOGIC_W   = CORE_NUM * CORE_IN;

  logic [LOGIC_W-1:0] logicIn;

  // Gather each logical core input from its legs; multi-leg inputs are OR gates
  always_comb begin
    logicIn = '0;
    for (int c = 0; c < CORE_NUM; c++) begin
      for (int j = 0; j < CORE_IN; j++) begin
        for (int f = 0; f < OR_FANIN; f++) begin
          if (f < legsOf(j, OR_LOW, OR_FANIN)) begin
            logicIn[c*CORE_IN + j] = logicIn[c*CORE_IN + j] |
              demuxOut[demuxOf(c, termOf(j, f, OR_LOW, OR_FANIN), CH_NUM) * CORE_NUM + c];
          end
        end
      end
    end
  end

  // Physical ports past the last logical core mirror it (broadcast copies)
  for (genvar p = 0; p < PHYS_NUM; p++) begin : g_phys
    localparam int SRC = (p < CORE_NUM) ? p : CORE_NUM - 1;
    assign coreData[p*CORE_IN +: CORE_IN] = logicIn[SRC*CORE_IN +: CORE_IN];
  end

endmodule

// File: rtl/scr_datapath.sv
module scr_datapath
  import scr_pkg::*;
#(
  parameter int CH_NUM       = 4,
  parameter int CORE_NUM     = 3,
  parameter int CORE_IN      = 3,
  parameter int OR_LOW       = 1,
  parameter int OR_FANIN     = 2,
  parameter int BCAST_COPIES = 2
) (
  input  logic                                           clk,
  input  logic                                           rstN,
  input  strobes_t                                       strobe,
  input  logic [CH_NUM*$clog2(CORE_NUM+1)-1:0]           shadowBits,
  input  logic [CH_NUM-1:0]                              chanIn,
  output logic [CH_NUM*$clog2(CORE_NUM+1)-1:0]           activeAddr,
  output logic [CH_NUM*CORE_NUM-1:0]                     demuxOut,
  output logic [(CORE_NUM-1+BCAST_COPIES)*CORE_IN-1:0]   coreData
);
  localparam int ADDR_W  = $clog2(CORE_NUM + 1);
  localparam int CHAIN_W = CH_NUM * ADDR_W;
  localparam logic [ADDR_W-1:0]  PARK     = ADDR_W'(CORE_NUM);
  localparam logic [CHAIN_W-1:0] PARK_ALL = {CH_NUM{PARK}};

  // Active addresses: held for a pattern group, replaced only on load
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeAddr <= PARK_ALL;
    end else if (strobe.load) begin
      activeAddr <= shadowBits;
    end
  end

  for (genvar d = 0; d < CH_NUM; d++) begin : g_dmx
    scr_demux #(
      .DEST_NUM (CORE_NUM),
      .ADDR_W   (ADDR_W)
    ) u_dmx (
      .chanBit (chanIn[d]),
      .sel     (activeAddr[d*ADDR_W +: ADDR_W]),
      .dest    (demuxOut[d*CORE_NUM +: CORE_NUM])
    );
  end

  scr_route #(
    .CH_NUM       (CH_NUM),
    .CORE_NUM     (CORE_NUM),
    .CORE_IN      (CORE_IN),
    .OR_LOW       (OR_LOW),
    .OR_FANIN     (OR_FANIN),
    .BCAST_COPIES (BCAST_COPIES)
  ) u_route (
    .demuxOut (demuxOut),
    .coreData (coreData)
  );

endmodule

// File: rtl/scan_chan_router.sv
module scan_chan_router
  import scr_pkg::*;
#(
  parameter int CH_NUM       = 4,  // tester input channels; must cover every terminal of a core
  parameter int CORE_NUM     = 3,  // distinct logical cores
  parameter int CORE_IN      = 3,  // decompressor inputs per core
  parameter int OR_LOW       = 1,  // low-order inputs built as OR gates
  parameter int OR_FANIN     = 2,  // legs per OR-gated input
  parameter int BCAST_COPIES = 2   // physical copies of the last core
) (
  input  logic                                           clk,
  input  logic                                           rstN,
  input  logic [CH_NUM-1:0]                              chanIn,
  input  logic                                           cfgShiftEn,
  input  logic                                           cfgSerIn,
  input  logic                                           cfgUpdate,
  output logic [(CORE_NUM-1+BCAST_COPIES)*CORE_IN-1:0]   coreData
);
  localparam int ADDR_W  = $clog2(CORE_NUM + 1);
  localparam int CHAIN_W = CH_NUM * ADDR_W;

  strobes_t                    strobe;
  logic [CHAIN_W-1:0]          shadowBits;
  logic [CHAIN_W-1:0]          activeAddr;
  logic [CH_NUM*CORE_NUM-1:0]  demuxOut;

  scr_ctrl #(
    .CH_NUM   (CH_NUM),
    .CORE_NUM (CORE_NUM)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgShiftEn (cfgShiftEn),
    .cfgSerIn   (cfgSerIn),
    .cfgUpdate  (cfgUpdate),
    .shadowBits (shadowBits),
    .strobe     (strobe)
  );

  scr_datapath #(
    .CH_NUM       (CH_NUM),
    .CORE_NUM     (CORE_NUM),
    .CORE_IN      (CORE_IN),
    .OR_LOW       (OR_LOW),
    .OR_FANIN     (OR_FANIN),
    .BCAST_COPIES (BCAST_COPIES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .shadowBits (shadowBits),
    .chanIn     (chanIn),
    .activeAddr (activeAddr),
    .demuxOut   (demuxOut),
    .coreData   (coreData)
  );

endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
  parameter int CH_NUM   = 4,
  parameter int CORE_NUM = 3
) (
  input logic                                    clk,
  input logic                                    rstN,
  input logic                                    cfgShiftEn,
  input logic                                    cfgSerIn,
  input logic                                    cfgUpdate,
  input logic [CH_NUM*$clog2(CORE_NUM+1)-1:0]    shadowBits,
  input logic [CH_NUM*$clog2(CORE_NUM+1)-1:0]    activeAddr,
  input logic [CH_NUM*CORE_NUM-1:0]              demuxOut
);
  localparam int ADDR_W  = $clog2(CORE_NUM + 1);
  localparam int CHAIN_W = CH_NUM * ADDR_W;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgUpdate |=> $stable(activeAddr)); // R2

  AST_UPDATE_COPY: assert property (@(posedge clk) disable iff (!rstN)
    cfgUpdate |=> (activeAddr == $past(shadowBits))); // R4

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    cfgShiftEn |=> (shadowBits[CHAIN_W-1] == $past(cfgSerIn))); // R3

  AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgShiftEn |=> $stable(shadowBits)); // R3

  for (genvar d = 0; d < CH_NUM; d++) begin : g_chk
    AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(demuxOut[d*CORE_NUM +: CORE_NUM])); // R1

    AST_PARK_SILENT: assert property (@(posedge clk) disable iff (!rstN)
      (activeAddr[d*ADDR_W +: ADDR_W] >= ADDR_W'(CORE_NUM))
        |-> (demuxOut[d*CORE_NUM +: CORE_NUM] == '0)); // R6
  end

endmodule

bind scan_chan_router scr_checker #(
  .CH_NUM   (CH_NUM),
  .CORE_NUM (CORE_NUM)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgShiftEn (cfgShiftEn),
  .cfgSerIn   (cfgSerIn),
  .cfgUpdate  (cfgUpdate),
  .shadowBits (shadowBits),
  .activeAddr (activeAddr),
  .demuxOut   (demuxOut)
);

// File: tb/test_scan_chan_router.sv
`timescale 1ns/1ps
module test_scan_chan_router;
  localparam int CH    = 4;
  localparam int CORES = 3;
  localparam int CIN   = 3;
  localparam int PHYS  = 4;
  localparam int DW    = PHYS * CIN;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [CH-1:0] chanIn = '0;
  logic          cfgShiftEn = 1'b0;
  logic          cfgSerIn = 1'b0;
  logic          cfgUpdate = 1'b0;
  logic [DW-1:0] coreData;

  int    nChecks = 0;
  int    nFail = 0;
  bit    finished = 1'b0;
  item_t sbQ[$];
  int    modelAddr[CH] = '{3, 3, 3, 3};
  int    pendAddr[CH]  = '{0, 0, 0, 0};

  always #2.5 clk = ~clk;

  scan_chan_router i_scan_chan_router (
    .clk        (clk),
    .rstN       (rstN),
    .chanIn     (chanIn),
    .cfgShiftEn (cfgShiftEn),
    .cfgSerIn   (cfgSerIn),
    .cfgUpdate  (cfgUpdate),
    .coreData   (coreData)
  );

  // Expected routing (R7, R8, R9): core c terminal t sits on channel (c+t)%4;
  // input 0 = terminals 0,1 ORed; input 1 = terminal 2; input 2 = terminal 3
  function automatic logic [DW-1:0] model(logic [CH-1:0] ch);
    logic [DW-1:0] r = '0;
    for (int p = 0; p < PHYS; p++) begin
      int c = (p < CORES) ? p : CORES - 1;
      for (int t = 0; t < 4; t++) begin
        int d   = (c + t) % CH;
        int inp = (t < 2) ? 0 : t - 1;
        if (ch[d] && modelAddr[d] == c) r[p*CIN + inp] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic drive(input logic [CH-1:0] ch, input string tag);
    @(negedge clk);
    chanIn = ch;
    sbQ.push_back('{model(ch), tag});
    @(posedge clk);
  endtask

  // R3: chain bit 2d+b holds bit b of channel d's address; bit 0 is sent first
  task automatic shiftBits(input int av[CH]);
    for (int k = 0; k < 2 * CH; k++) begin
      @(negedge clk);
      cfgShiftEn = 1'b1;
      cfgSerIn   = 1'((av[k / 2] >> (k % 2)) & 1);
    end
    @(negedge clk);
    cfgShiftEn = 1'b0;
    pendAddr   = av;
  endtask

  task automatic pulseUpdate();
    @(negedge clk);
    cfgUpdate = 1'b1;
    @(negedge clk);
    cfgUpdate = 1'b0;
    modelAddr = pendAddr;
  endtask

  task automatic loadAddr(input int av[CH]);
    shiftBits(av);
    pulseUpdate();
  endtask

  // Monitor: pops expected items and compares away from the clock edge
  initial begin
    forever begin
      item_t it;
      wait (sbQ.size() > 0);
      #1;
      it = sbQ.pop_front();
      nChecks++;
      if (coreData !== it.exp) begin
        nFail++;
        $display("FAIL %s: coreData got %h expected %h", it.tag, coreData, it.exp);
      end
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: run did not complete, got hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    drive(4'hF, "R5 reset parks all channels");

    loadAddr('{0, 1, 2, 3});
    for (int d = 0; d < CH; d++) drive(4'(1 << d), "R3 R1 R7 distinct addresses one-hot");
    drive(4'hF, "R1 R6 distinct addresses all ones");

    loadAddr('{0, 0, 3, 3});
    drive(4'b0001, "R8 first leg alone");
    drive(4'b0010, "R8 second leg alone");
    drive(4'b0011, "R8 both legs");

    loadAddr('{2, 2, 2, 2});
    drive(4'hF, "R9 broadcast copy all ones");
    drive(4'b0101, "R9 broadcast copy pattern");

    loadAddr('{3, 1, 3, 1});
    drive(4'hF, "R6 parked channels silent");

    shiftBits('{0, 0, 0, 0});
    drive(4'hF, "R2 shift without update");
    pulseUpdate();
    drive(4'hF, "R4 update applies chain");

    shiftBits('{1, 1, 1, 1});
    @(negedge clk);
    cfgShiftEn = 1'b1;
    cfgSerIn   = 1'b1;
    cfgUpdate  = 1'b1;
    @(negedge clk);
    cfgShiftEn = 1'b0;
    cfgUpdate  = 1'b0;
    modelAddr  = pendAddr;
    drive(4'hF, "R4 update with shift takes old chain");
    drive(4'b1010, "R4 update with shift pattern");

    for (int n = 0; n < 30; n++) begin
      int av[CH];
      for (int d = 0; d < CH; d++) av[d] = int'($urandom_range(0, 3));
      loadAddr(av);
      for (int d = 0; d < CH; d++) drive(4'(1 << d), "R7 R1 random one-hot");
      drive(4'hF, "R8 random all ones");
      drive(4'($urandom), "R7 R8 R9 random word");
    end

    wait (sbQ.size() == 0);
    #2;
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule